// File: doc/BRIEF.md
# Received Frame Posting and Port Interrupt Logic

This block sits in one port of a serial storage host controller. Each cycle it may accept one frame that has come up from the attached drive. It recognises three frame kinds. The register frame carries ending status. The set-device-bits frame closes queued commands. The PIO-setup frame announces a programmed data phase. The block copies a recognised frame into the port's received-frame area at the slot that belongs to its kind. It then updates the task-file status and error registers and sets sticky interrupt-status bits. Software clears those bits by writing ones.

The block watches the status byte of every recognised frame. A frame that reports an error raises the task-file-error interrupt and sets an error-hold flag, whatever the frame's own interrupt request says. The command-issue logic reads this flag and stops issuing new commands until software signals recovery.

A set-device-bits frame is handled further. If it reports no error, the slot mask it carries retires those slots from the active-command vector. If it reports an error, the failing command's slot, status, error byte and sixteen bytes of command content are recorded instead, and the active vector is left alone.

Top module: `rx_fis_post`

## Requirements
- R1: A frame's type is byte 0, and frame byte i sits on `frm_bytes[8i+7:8i]`. Type 8'h34 (register frame) stores bytes 0..19 at area offset 0x40. Type 8'hA1 (set-device-bits) stores bytes 0..7 at offset 0x58. Type 8'h5F (PIO setup) stores bytes 0..19 at offset 0x20. Area bytes outside the written range are unchanged.
- R2: Any other type code is ignored. It causes no area write, no task-file change and no interrupt-status change, even when its status byte shows an error.
- R3: A recognised frame raises its own interrupt bit only when bit 6 of byte 1 is set. The bits are register frame = bit 0, PIO setup = bit 1 and set-device-bits = bit 2 of `int_stat`.
- R4: When bit 0 (error) of status byte 2 of a recognised frame is set, `int_stat` bit 3 (task-file error) and `err_hold` are set on the next cycle, independent of byte 1 bit 6.
- R5: A register or PIO-setup frame loads byte 2 into `tf_status` and byte 3 into `tf_error`.
- R6: A set-device-bits frame loads byte 3 into `tf_error`. It replaces only the `tf_status` bits under mask 8'h77 with byte 2. Bits 7 and 3 keep their previous value.
- R7: A set-device-bits frame without error clears from `act_vec` every slot whose bit is set in the mask carried in bytes 4..7, with slot n at bit n of that mask. Slots set by `act_set` are added in the same cycle.
- R8: A set-device-bits frame with error loads `ecap_slot` from `cmd_slot`, `ecap_status` from byte 2 masked with 8'h77, `ecap_error` from byte 3 and `ecap_ctx` from `cmd_ctx`. It leaves `act_vec` unchanged.
- R9: Interrupt-status bits are sticky. A one in `int_clr` clears that bit on the next cycle. If a bit is set and cleared in the same cycle, it ends up set.
- R10: `irq` is high exactly when some bit is set in both `int_stat` and `int_en`.
- R11: `err_hold` stays set until `hold_release` is pulsed. An error frame that arrives in the same cycle as the release leaves the flag set.
- R12: After synchronous reset, `int_stat`, `tf_status`, `tf_error`, `act_vec`, `err_hold`, `irq` and the whole area read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | A frame is presented this cycle |
| frm_bytes | input | 160 | Frame content, byte i at bits 8i+7:8i |
| cmd_slot | input | 5 | Slot of the command the frame refers to |
| cmd_ctx | input | 128 | Sixteen bytes of that command's content |
| act_set | input | 32 | Slots newly marked active by the command engine |
| act_vec | output | 32 | Active-command vector |
| tf_status | output | 8 | Task-file status byte |
| tf_error | output | 8 | Task-file error byte |
| err_hold | output | 1 | Error hold, blocks command issue |
| hold_release | input | 1 | Software recovery pulse clearing the hold |
| int_en | input | 4 | Interrupt enables |
| int_clr | input | 4 | Write-one-to-clear pulses for interrupt status |
| int_stat | output | 4 | Sticky interrupt status |
| irq | output | 1 | Port interrupt request |
| area_addr | input | 7 | Received-frame area read address |
| area_data | output | 8 | Byte read from the area |
| ecap_slot | output | 5 | Captured failing slot |
| ecap_status | output | 8 | Captured masked status |
| ecap_error | output | 8 | Captured error byte |
| ecap_ctx | output | 128 | Captured command content |

## Verification
Two kinds of event can land on the same edge. A new frame can set an interrupt bit while software's write-one-to-clear of that same bit arrives. An error frame can set the hold while the recovery pulse releases it. The bench drives both inputs in one cycle and then reads the result one cycle later. The bit or flag must read set, while any other bit named in the clear must read cleared. A table of frames walks every kind with its interrupt request on and off and its error bit on and off. Each result is compared against a bench model of the area, the task file and the interrupt bits.

// File: rtl/rxf_pkg.sv
// Shared constants and types for received-frame posting.
// Assumes frames are at most 20 bytes with the type code in byte 0.
package rxf_pkg;
    localparam int FRM_BYTES = 20;
    localparam int FRM_W     = FRM_BYTES * 8;
    localparam int CTX_BYTES = 16;

    localparam logic [7:0] FT_REG = 8'h34;
    localparam logic [7:0] FT_SDB = 8'hA1;
    localparam logic [7:0] FT_PIO = 8'h5F;

    localparam int OFF_REG = 'h40;
    localparam int OFF_SDB = 'h58;
    localparam int OFF_PIO = 'h20;
    localparam int LEN_REG = 20;
    localparam int LEN_SDB = 8;
    localparam int LEN_PIO = 20;

    localparam int IRQ_N  = 4;
    localparam int IB_REG = 0;
    localparam int IB_PIO = 1;
    localparam int IB_SDB = 2;
    localparam int IB_TFE = 3;

    localparam logic [7:0] SDB_ST_MASK = 8'h77;

    typedef enum logic [1:0] {FK_NONE, FK_REG, FK_SDB, FK_PIO} frm_kind_e;
endpackage

// File: rtl/rxf_decode.sv
// Decodes a frame type code into kind, area offset, length and the
// per-kind interrupt bit. Purely combinational; assumes the offset
// plus length of every kind fits the area.
module rxf_decode
    import rxf_pkg::*;
#(
    parameter int AREA_AW = 7
) (
    input  logic [7:0]         ftype,
    input  logic               irq_req,
    output frm_kind_e          kind,
    output logic [AREA_AW-1:0] offset,
    output logic [4:0]         nbytes,
    output logic [IRQ_N-1:0]   type_irq
);
    // Map type code to kind, placement and requested interrupt.
    always_comb begin
        kind     = FK_NONE;
        offset   = '0;
        nbytes   = '0;
        type_irq = '0;
        case (ftype)
            FT_REG: begin
                kind = FK_REG; offset = AREA_AW'(OFF_REG); nbytes = 5'(LEN_REG);
                type_irq[IB_REG] = irq_req;
            end
            FT_SDB: begin
                kind = FK_SDB; offset = AREA_AW'(OFF_SDB); nbytes = 5'(LEN_SDB);
                type_irq[IB_SDB] = irq_req;
            end
            FT_PIO: begin
                kind = FK_PIO; offset = AREA_AW'(OFF_PIO); nbytes = 5'(LEN_PIO);
                type_irq[IB_PIO] = irq_req;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxf_area.sv
// Received-frame area: byte-wide storage written a whole frame per
// cycle at a given offset, read one byte at a time combinationally.
// Assumes offset + nbytes never exceeds AREA_BYTES.
module rxf_area
    import rxf_pkg::*;
#(
    parameter int AREA_BYTES = 128,
    localparam int AREA_AW   = $clog2(AREA_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AREA_AW-1:0] offset,
    input  logic [4:0]         nbytes,
    input  logic [FRM_W-1:0]   frm_bytes,
    input  logic [AREA_AW-1:0] rd_addr,
    output logic [7:0]         rd_data
);
    logic [7:0] mem [AREA_BYTES];

    // Clear on reset, otherwise copy the first nbytes frame bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < AREA_BYTES; a++) mem[a] <= '0;
        end else if (we) begin
            for (int i = 0; i < FRM_BYTES; i++) begin
                if (i < int'(nbytes)) mem[offset + AREA_AW'(i)] <= frm_bytes[8*i +: 8];
            end
        end
    end

    // Read port.
    assign rd_data = mem[rd_addr];

    // R1: a frame must land entirely inside the area.
    assert_fit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(offset) + int'(nbytes) <= AREA_BYTES));
endmodule

// File: rtl/rxf_irq.sv
// Sticky interrupt-status register with write-one-to-clear and enable
// masking. A set arriving with a clear of the same bit wins.
module rxf_irq
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] set_mask,
    input  logic [IRQ_N-1:0] clr_mask,
    input  logic [IRQ_N-1:0] enable,
    output logic [IRQ_N-1:0] stat,
    output logic             irq
);
    // Hold, clear then set the status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_mask) | set_mask;
    end

    // Port request from enabled status.
    assign irq = |(stat & enable);

    // R9: bits cleared without a competing set read zero next cycle.
    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~set_mask)) |=> ((stat & $past(clr_mask & ~set_mask)) == '0));
    // R9: without set or clear the status is unchanged.
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0 && clr_mask == '0) |=> $stable(stat));
    // R9: a set bit is visible on the next cycle regardless of clears.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask) |=> ((stat & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/rx_fis_post.sv
// Top of received-frame posting: stores frames, updates the task file,
// raises interrupt status, keeps the error hold, retires queued slots
// and captures the failing command on an errored set-device-bits frame.
// Assumes at most one frame per cycle and NSLOT <= 32.
module rx_fis_post
    import rxf_pkg::*;
#(
    parameter int NSLOT      = 32,
    parameter int AREA_BYTES = 128,
    localparam int SLOT_W    = $clog2(NSLOT),
    localparam int AREA_AW   = $clog2(AREA_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frm_valid,
    input  logic [FRM_W-1:0]       frm_bytes,
    input  logic [SLOT_W-1:0]      cmd_slot,
    input  logic [CTX_BYTES*8-1:0] cmd_ctx,
    input  logic [NSLOT-1:0]       act_set,
    output logic [NSLOT-1:0]       act_vec,
    output logic [7:0]             tf_status,
    output logic [7:0]             tf_error,
    output logic                   err_hold,
    input  logic                   hold_release,
    input  logic [IRQ_N-1:0]       int_en,
    input  logic [IRQ_N-1:0]       int_clr,
    output logic [IRQ_N-1:0]       int_stat,
    output logic                   irq,
    input  logic [AREA_AW-1:0]     area_addr,
    output logic [7:0]             area_data,
    output logic [SLOT_W-1:0]      ecap_slot,
    output logic [7:0]             ecap_status,
    output logic [7:0]             ecap_error,
    output logic [CTX_BYTES*8-1:0] ecap_ctx
);
    frm_kind_e          kind;
    logic [AREA_AW-1:0] offset;
    logic [4:0]         nbytes;
    logic [IRQ_N-1:0]   type_irq;
    logic [IRQ_N-1:0]   set_mask;
    logic [7:0]         st_byte, er_byte;
    logic [NSLOT-1:0]   done_mask;
    logic               known, is_sdb, has_err, take;

    assign st_byte   = frm_bytes[23:16];
    assign er_byte   = frm_bytes[31:24];
    assign done_mask = frm_bytes[32 +: NSLOT];

    rxf_decode #(.AREA_AW(AREA_AW)) u_dec (
        .ftype    (frm_bytes[7:0]),
        .irq_req  (frm_bytes[14]),
        .kind     (kind),
        .offset   (offset),
        .nbytes   (nbytes),
        .type_irq (type_irq)
    );

    // Qualify the frame and form the interrupt set request.
    always_comb begin
        known    = (kind != FK_NONE);
        take     = frm_valid && known;
        is_sdb   = take && (kind == FK_SDB);
        has_err  = take && st_byte[0];
        set_mask = take ? type_irq : '0;
        set_mask[IB_TFE] = has_err;
    end

    rxf_area #(.AREA_BYTES(AREA_BYTES)) u_area (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (take),
        .offset    (offset),
        .nbytes    (nbytes),
        .frm_bytes (frm_bytes),
        .rd_addr   (area_addr),
        .rd_data   (area_data)
    );

    rxf_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (int_clr),
        .enable   (int_en),
        .stat     (int_stat),
        .irq      (irq)
    );

    // Task-file update: full load, or masked merge for set-device-bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_status <= '0;
            tf_error  <= '0;
        end else if (take) begin
            tf_error <= er_byte;
            if (is_sdb) tf_status <= (tf_status & ~SDB_ST_MASK) | (st_byte & SDB_ST_MASK);
            else        tf_status <= st_byte;
        end
    end

    // Error hold: set by any errored frame, released by software.
    always_ff @(posedge clk) begin
        if (!rst_n)            err_hold <= 1'b0;
        else if (has_err)      err_hold <= 1'b1;
        else if (hold_release) err_hold <= 1'b0;
    end

    // Active vector: retire completed slots, add newly issued ones.
    always_ff @(posedge clk) begin
        if (!rst_n) act_vec <= '0;
        else        act_vec <= (act_vec & ~((is_sdb && !has_err) ? done_mask : '0)) | act_set;
    end

    // Error capture for a failed set-device-bits completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecap_slot   <= '0;
            ecap_status <= '0;
            ecap_error  <= '0;
            ecap_ctx    <= '0;
        end else if (is_sdb && has_err) begin
            ecap_slot   <= cmd_slot;
            ecap_status <= st_byte & SDB_ST_MASK;
            ecap_error  <= er_byte;
            ecap_ctx    <= cmd_ctx;
        end
    end

    // R4: an errored recognised frame sets hold and task-file error.
    assert_err_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && known && frm_bytes[16]) |=> (err_hold && int_stat[IB_TFE]));
    // R6: set-device-bits never touches status bits outside the mask.
    assert_sdb_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && kind == FK_SDB) |=> ((tf_status & 8'h88) == $past(tf_status & 8'h88)));
    // R2: an unrecognised frame changes neither status nor task file.
    assert_unknown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !known && int_clr == '0) |=> ($stable(int_stat) && $stable(tf_status)));
    // R7: a clean completion leaves its slots inactive.
    assert_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && kind == FK_SDB && !frm_bytes[16] && act_set == '0)
            |=> ((act_vec & $past(done_mask)) == '0));
    // R11: the hold only drops after a release pulse.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_hold) |-> $past(hold_release));
endmodule

// File: tb/rx_fis_post_bench.sv
`timescale 1ns/1ps
module rx_fis_post_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frm_valid = 1'b0;
    logic [159:0] frm_bytes = '0;
    logic [4:0]   cmd_slot = '0;
    logic [127:0] cmd_ctx = '0;
    logic [31:0]  act_set = '0;
    logic [31:0]  act_vec;
    logic [7:0]   tf_status, tf_error;
    logic         err_hold;
    logic         hold_release = 1'b0;
    logic [3:0]   int_en = '0;
    logic [3:0]   int_clr = '0;
    logic [3:0]   int_stat;
    logic         irq;
    logic [6:0]   area_addr = '0;
    logic [7:0]   area_data;
    logic [4:0]   ecap_slot;
    logic [7:0]   ecap_status, ecap_error;
    logic [127:0] ecap_ctx;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] mdl_area [128];
    logic [7:0] mdl_tf = '0;

    always #10 clk = ~clk;

    rx_fis_post u_rx_fis_post (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_bytes(frm_bytes),
        .cmd_slot(cmd_slot), .cmd_ctx(cmd_ctx), .act_set(act_set), .act_vec(act_vec),
        .tf_status(tf_status), .tf_error(tf_error), .err_hold(err_hold),
        .hold_release(hold_release), .int_en(int_en), .int_clr(int_clr),
        .int_stat(int_stat), .irq(irq), .area_addr(area_addr), .area_data(area_data),
        .ecap_slot(ecap_slot), .ecap_status(ecap_status), .ecap_error(ecap_error),
        .ecap_ctx(ecap_ctx)
    );

    // type, byte1, status, expected int_stat, expected hold
    localparam logic [28:0] VEC [12] = '{
        {8'h34, 8'h40, 8'h50, 4'b0001, 1'b0},
        {8'h34, 8'h00, 8'h50, 4'b0000, 1'b0},
        {8'h5F, 8'h40, 8'h58, 4'b0010, 1'b0},
        {8'h5F, 8'h00, 8'h58, 4'b0000, 1'b0},
        {8'hA1, 8'h40, 8'h40, 4'b0100, 1'b0},
        {8'hA1, 8'h00, 8'h40, 4'b0000, 1'b0},
        {8'h34, 8'h00, 8'h51, 4'b1000, 1'b1},
        {8'h34, 8'h40, 8'h41, 4'b1001, 1'b1},
        {8'hA1, 8'h40, 8'h41, 4'b1100, 1'b1},
        {8'h5F, 8'h00, 8'h01, 4'b1000, 1'b1},
        {8'h00, 8'h40, 8'h41, 4'b0000, 1'b0},
        {8'h27, 8'h40, 8'h01, 4'b0000, 1'b0}
    };

    task automatic chk(input string tag, input logic [159:0] got, input logic [159:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // One cycle of stimulus; results are visible when it returns.
    task automatic cyc(input logic v, input logic [159:0] f, input logic [3:0] clr,
                       input logic rel, input logic [31:0] aset);
        @(negedge clk);
        frm_valid = v; frm_bytes = f; int_clr = clr; hold_release = rel; act_set = aset;
        @(negedge clk);
        frm_valid = 0; int_clr = '0; hold_release = 0; act_set = '0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        area_addr = 7'(a);
        #1 d = area_data;
    endtask

    function automatic logic [159:0] mk(input logic [7:0] t, input logic [7:0] b1,
                                        input logic [7:0] st, input logic [7:0] eb);
        logic [159:0] f = '0;
        f[7:0] = t; f[15:8] = b1; f[23:16] = st; f[31:24] = eb;
        return f;
    endfunction

    // Bench model of the area and task file, from R1, R5, R6.
    task automatic model(input logic [159:0] f);
        int off, len;
        off = -1; len = 0;
        case (f[7:0])
            8'h34: begin off = 'h40; len = 20; end
            8'hA1: begin off = 'h58; len = 8; end
            8'h5F: begin off = 'h20; len = 20; end
            default: ;
        endcase
        if (off >= 0) begin
            for (int i = 0; i < len; i++) mdl_area[off + i] = f[8*i +: 8];
            if (f[7:0] == 8'hA1) mdl_tf = (mdl_tf & 8'h88) | (f[23:16] & 8'h77);
            else mdl_tf = f[23:16];
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [159:0] f;
        for (int a = 0; a < 128; a++) mdl_area[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 int_stat", int_stat, 0);
        chk("R12 tf_status", tf_status, 0);
        chk("R12 tf_error", tf_error, 0);
        chk("R12 act_vec", act_vec, 0);
        chk("R12 err_hold", err_hold, 0);
        chk("R12 irq", irq, 0);
        rd('h40, d); chk("R12 area", d, 0);
        rd('h58, d); chk("R12 area sdb", d, 0);

        // Table walk: R1, R2, R3, R4, R5, R6
        for (int k = 0; k < 12; k++) begin
            logic [28:0] v;
            v = VEC[k];
            cyc(0, '0, 4'hF, 1, '0);
            f = mk(v[28:21], v[20:13], v[12:5], 8'hE0 + 8'(k));
            f[159:152] = 8'h30 + 8'(k);
            cyc(1, f, '0, 0, '0);
            model(f);
            chk($sformatf("R3 R4 int_stat vec %0d", k), int_stat, v[4:1]);
            chk($sformatf("R4 err_hold vec %0d", k), err_hold, v[0]);
            chk($sformatf("R5 R6 R2 tf_status vec %0d", k), tf_status, mdl_tf);
            for (int a = 'h20; a < 'h64; a++) begin
                rd(a, d);
                chk($sformatf("R1 R2 area[%0h] vec %0d", a, k), d, mdl_area[a]);
            end
        end

        // R7: clean completion retires slots named in bytes 4..7
        cyc(0, '0, 4'hF, 1, 32'h30);
        chk("R7 act after set", act_vec, 32'h30);
        f = mk(8'hA1, 8'h00, 8'h40, 8'h00); f[39:32] = 8'h10;
        cyc(1, f, '0, 0, '0); model(f);
        chk("R7 act after completion", act_vec, 32'h20);
        chk("R6 tf_error sdb", tf_error, 8'h00);

        // R8: errored completion captures context, keeps active slots
        cmd_slot = 5'd5; cmd_ctx = 128'h0F0E0D0C0B0A09080706050403020100;
        f = mk(8'hA1, 8'h00, 8'hC9, 8'h04); f[39:32] = 8'h20;
        cyc(1, f, '0, 0, '0); model(f);
        chk("R8 act kept", act_vec, 32'h20);
        chk("R8 ecap_slot", ecap_slot, 5'd5);
        chk("R8 ecap_status", ecap_status, 8'h41);
        chk("R8 ecap_error", ecap_error, 8'h04);
        chk("R8 ecap_ctx", ecap_ctx, 128'h0F0E0D0C0B0A09080706050403020100);

        // R6: masked merge keeps bits 7 and 3
        cyc(0, '0, 4'hF, 1, '0);
        f = mk(8'h34, 8'h00, 8'h88, 8'h00); cyc(1, f, '0, 0, '0); model(f);
        chk("R5 tf full load", tf_status, 8'h88);
        f = mk(8'hA1, 8'h00, 8'h50, 8'h00); cyc(1, f, '0, 0, '0); model(f);
        chk("R6 tf merge a", tf_status, 8'hD8);
        f = mk(8'hA1, 8'h00, 8'h0E, 8'h02); cyc(1, f, '0, 0, '0); model(f);
        chk("R6 tf merge b", tf_status, 8'h8E);
        chk("R6 tf_error load", tf_error, 8'h02);

        // R9: set and clear of one bit in one cycle, sticky, W1C
        cyc(0, '0, 4'hF, 1, '0);
        cyc(1, mk(8'h34, 8'h40, 8'h50, 8'h00), 4'b0001, 0, '0);
        chk("R9 set wins over clear", int_stat, 4'b0001);
        cyc(0, '0, '0, 0, '0);
        chk("R9 sticky", int_stat, 4'b0001);
        cyc(1, mk(8'h34, 8'h00, 8'h51, 8'h00), '0, 0, '0);
        chk("R9 accumulate", int_stat, 4'b1001);
        cyc(1, mk(8'h34, 8'h40, 8'h50, 8'h00), 4'b1001, 0, '0);
        chk("R9 partial clear", int_stat, 4'b0001);

        // R10: enable masking
        int_en = 4'b0000; #1 chk("R10 disabled", irq, 0);
        int_en = 4'b0100; #1 chk("R10 other enable", irq, 0);
        int_en = 4'b0001; #1 chk("R10 enabled", irq, 1);
        cyc(0, '0, 4'b0001, 0, '0);
        chk("R9 clear", int_stat, 4'b0000);
        chk("R10 cleared", irq, 0);

        // R11: release and error in the same cycle, then release alone
        cyc(1, mk(8'h5F, 8'h00, 8'h01, 8'h00), '0, 1, '0);
        chk("R11 set wins over release", err_hold, 1);
        cyc(0, '0, '0, 0, '0);
        chk("R11 hold persists", err_hold, 1);
        cyc(0, '0, '0, 1, '0);
        chk("R11 released", err_hold, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule